// File: doc/BRIEF.md
# Multiplexed Seven-Segment Display Scanner

The scanner drives a bank of common-anode seven-segment digits, up to eight of them, over a single shared segment bus. Only one digit is lit at a time. A per-digit select line, active low, picks the lit digit. Each digit holds the bus for a fixed number of clocks, and then the scan moves on to the next digit. The user supplies a packed vector of 4-bit BCD values, one decimal-point bit per digit, a lamp-test control and a blanking enable.

Each scan slot opens with one clock in which every digit is dark, so the segment pattern never reaches the wrong digit while the select changes. When blanking is enabled, zeros at the most significant end are suppressed. A blank state ripples from the top digit down through each zero digit, and the least significant digit always shows its value. Lamp test lights every segment and the decimal point of the digit being scanned. Codes above nine show as a dark digit.

Digit 0 is the least significant digit. It uses `bcd_i[3:0]`, `dp_i[0]` and `dig_sel_o[0]`. Digit i uses `bcd_i[4i+3:4i]`. `DWELL_CYCLES` must be at least 2. For a flicker-free display, `NUM_DIGITS*DWELL_CYCLES` clocks must be shorter than 1/60 s.

Top module: `seg_scan_top`

## Requirements
- R1: While `rst_ni` is low, `dig_sel_o` is all ones, `seg_o` is 7'h7F and `dp_o` is 1. The first slot after reset belongs to digit 0.
- R2: At most one bit of `dig_sel_o` is low at any time. A low bit i means digit i is lit.
- R3: Each digit owns a slot of `DWELL_CYCLES` clocks. Slots go to digits 0, 1, ... `NUM_DIGITS-1` in that order, then back to 0.
- R4: In the first clock of every slot, `dig_sel_o` is all ones, `seg_o` is 7'h7F and `dp_o` is 1, even under lamp test.
- R5: In a lit cycle, a code from 0 to 9 drives `seg_o` low on the segments of that numeral. Bit 0 is segment a, through bit 6, which is segment g. The low bits are 0:abcdef, 1:bc, 2:abdeg, 3:abcdg, 4:bcfg, 5:acdfg, 6:acdefg, 7:abc, 8:all, 9:abcdfg.
- R6: Codes 10 to 15 give `seg_o` = 7'h7F in a lit cycle. These codes count as nonzero for blanking.
- R7: In a lit cycle without lamp test, `dp_o` is the inverse of the lit digit's `dp_i` bit, whether or not the digit is blanked.
- R8: In a lit cycle, lamp test forces `seg_o` to 0 and `dp_o` to 0. This overrides codes and blanking.
- R9: With `blank_en_i` high, digit i > 0 shows `seg_o` = 7'h7F when it and every higher digit hold code 0.
- R10: Digit 0 is never blanked. A zero there shows the numeral 0 even when all digits are zero.
- R11: With `blank_en_i` low, zero digits show the numeral 0 at every position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| bcd_i | input | 4*NUM_DIGITS | packed BCD codes, digit 0 in the low nibble |
| dp_i | input | NUM_DIGITS | decimal-point request per digit, active high |
| lamp_test_i | input | 1 | force all segments on |
| blank_en_i | input | 1 | enable leading-zero suppression |
| seg_o | output | 7 | segments a..g in bits 0..6, active low |
| dp_o | output | 1 | decimal point, active low |
| dig_sel_o | output | NUM_DIGITS | digit enables, one-hot active low |

## Verification
Several controls can act on the same lit cycle: lamp test, blanking of a leading zero, a dark code above nine, and the decimal point. The anti-ghost gap also coincides with every slot change. The bench holds lamp test high over all-zero values with blanking enabled. It expects the override to win in lit cycles and the gap to stay dark anyway. Other patterns place a code above nine and a nonzero digit above zero digits, so that blanking and code decoding overlap on the same cycles. Every clock is compared against a behavioural model that recomputes the suppression from the input values.

// File: rtl/seg_scan_pkg.sv
package seg_scan_pkg;

  localparam logic [6:0] SEG_DARK = 7'h7F;

  // active-low segment pattern, bit0 = a .. bit6 = g
  function automatic logic [6:0] bcd_to_seg_n(input logic [3:0] code);
    logic [6:0] on;
    case (code)
      4'd0:    on = 7'b0111111;
      4'd1:    on = 7'b0000110;
      4'd2:    on = 7'b1011011;
      4'd3:    on = 7'b1001111;
      4'd4:    on = 7'b1100110;
      4'd5:    on = 7'b1101101;
      4'd6:    on = 7'b1111101;
      4'd7:    on = 7'b0000111;
      4'd8:    on = 7'b1111111;
      4'd9:    on = 7'b1101111;
      default: on = 7'b0000000;
    endcase
    return ~on;
  endfunction

endpackage

// File: rtl/scan_timer.sv
module scan_timer #(
  parameter int NUM_DIGITS   = 8,
  parameter int DWELL_CYCLES = 1000,
  localparam int IDX_W = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1,
  localparam int CNT_W = (DWELL_CYCLES > 1) ? $clog2(DWELL_CYCLES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [IDX_W-1:0] idx_o,
  output logic             lit_o
);

  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DWELL_CYCLES - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_DIGITS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      idx_q <= '0;
    end else if (cnt_q == CNT_LAST) begin
      cnt_q <= '0;
      idx_q <= (idx_q == IDX_LAST) ? '0 : idx_q + 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // first count of a slot is the dark gap
  assign lit_o = (cnt_q != '0);
  assign idx_o = idx_q;

  // R4
  gap_on_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(idx_q) |-> !lit_o);

  // R3
  idx_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q <= IDX_LAST);

endmodule

// File: rtl/blank_chain.sv
module blank_chain #(
  parameter int NUM_DIGITS = 8
) (
  input  logic [4*(NUM_DIGITS-1)-1:0] bcd_hi_i,   // digits 1..N-1
  input  logic                        blank_en_i,
  output logic [NUM_DIGITS-1:0]       blank_o
);

  // rb[i]: digit i and all above are zero, suppression on
  logic [NUM_DIGITS:1] rb;
  assign rb[NUM_DIGITS] = blank_en_i;

  for (genvar i = NUM_DIGITS - 1; i >= 1; i--) begin : g_stage
    assign rb[i]      = rb[i+1] & (bcd_hi_i[4*(i-1) +: 4] == 4'd0);
    assign blank_o[i] = rb[i];
  end

  assign blank_o[0] = 1'b0;

endmodule

// File: rtl/seg_drive.sv
module seg_drive
  import seg_scan_pkg::*;
#(
  parameter int NUM_DIGITS = 8,
  localparam int IDX_W = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  lit_i,
  input  logic [IDX_W-1:0]      idx_i,
  input  logic [3:0]            code_i,
  input  logic                  blank_i,
  input  logic                  dp_i,
  input  logic                  lamp_test_i,
  output logic [6:0]            seg_o,
  output logic                  dp_o,
  output logic [NUM_DIGITS-1:0] dig_sel_o
);

  always_comb begin
    seg_o     = SEG_DARK;
    dp_o      = 1'b1;
    dig_sel_o = '1;
    if (lit_i) begin
      dig_sel_o = ~(NUM_DIGITS'(1) << idx_i);
      if (lamp_test_i) begin
        seg_o = '0;
        dp_o  = 1'b0;
      end else begin
        seg_o = blank_i ? SEG_DARK : bcd_to_seg_n(code_i);
        dp_o  = ~dp_i;
      end
    end
  end

  // R6
  bad_code_dark_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dig_sel_o != '1 && !lamp_test_i && code_i > 4'd9) |-> seg_o == SEG_DARK);

endmodule

// File: rtl/seg_scan_top.sv
module seg_scan_top #(
  parameter int NUM_DIGITS   = 8,
  parameter int DWELL_CYCLES = 1000,
  localparam int IDX_W = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [4*NUM_DIGITS-1:0] bcd_i,
  input  logic [NUM_DIGITS-1:0]   dp_i,
  input  logic                    lamp_test_i,
  input  logic                    blank_en_i,
  output logic [6:0]              seg_o,
  output logic                    dp_o,
  output logic [NUM_DIGITS-1:0]   dig_sel_o
);

  logic [IDX_W-1:0]      idx;
  logic                  lit;
  logic [NUM_DIGITS-1:0] blank_vec;
  logic [3:0]            code_arr [NUM_DIGITS];

  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_split
    assign code_arr[i] = bcd_i[4*i +: 4];
  end

  scan_timer #(
    .NUM_DIGITS  (NUM_DIGITS),
    .DWELL_CYCLES(DWELL_CYCLES)
  ) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .idx_o (idx),
    .lit_o (lit)
  );

  blank_chain #(
    .NUM_DIGITS(NUM_DIGITS)
  ) u_blank (
    .bcd_hi_i  (bcd_i[4*NUM_DIGITS-1:4]),
    .blank_en_i(blank_en_i),
    .blank_o   (blank_vec)
  );

  seg_drive #(
    .NUM_DIGITS(NUM_DIGITS)
  ) u_drive (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lit_i      (lit),
    .idx_i      (idx),
    .code_i     (code_arr[idx]),
    .blank_i    (blank_vec[idx]),
    .dp_i       (dp_i[idx]),
    .lamp_test_i(lamp_test_i),
    .seg_o      (seg_o),
    .dp_o       (dp_o),
    .dig_sel_o  (dig_sel_o)
  );

  // R2
  one_digit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~dig_sel_o));

  // R8
  lamp_all_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lamp_test_i && dig_sel_o != '1) |-> (seg_o == 7'h00 && !dp_o));

  // R10
  lsd_shown_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dig_sel_o[0] && !lamp_test_i && bcd_i[3:0] == 4'd0) |-> seg_o != 7'h7F);

  // R4
  dark_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dig_sel_o == '1) |-> (seg_o == 7'h7F && dp_o));

endmodule

// File: tb/sim_seg_scan_top.sv
module sim_seg_scan_top;

  localparam int N  = 4;
  localparam int DW = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [4*N-1:0] bcd = '0;
  logic [N-1:0]   dp = '0;
  logic           lamp = 1'b0;
  logic           ben = 1'b0;
  logic [6:0]     seg;
  logic           dpo;
  logic [N-1:0]   sel;

  int  total = 0;
  int  bad = 0;
  bit  done = 1'b0;
  int  m_cnt = 0;
  int  m_idx = 0;

  always #10 clk = ~clk;

  seg_scan_top #(.NUM_DIGITS(N), .DWELL_CYCLES(DW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .bcd_i(bcd), .dp_i(dp),
    .lamp_test_i(lamp), .blank_en_i(ben),
    .seg_o(seg), .dp_o(dpo), .dig_sel_o(sel)
  );

  // behavioural slot model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0;
      m_idx = 0;
    end else if (m_cnt == DW - 1) begin
      m_cnt = 0;
      m_idx = (m_idx + 1) % N;
    end else begin
      m_cnt = m_cnt + 1;
    end
  end

  function automatic logic [6:0] numeral(input int v);
    case (v)
      0: return ~7'h3F;
      1: return ~7'h06;
      2: return ~7'h5B;
      3: return ~7'h4F;
      4: return ~7'h66;
      5: return ~7'h6D;
      6: return ~7'h7D;
      7: return ~7'h07;
      8: return ~7'h7F;
      9: return ~7'h6F;
      default: return 7'h7F;
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      automatic bit         lit = (m_cnt != 0);
      automatic int         v = int'(bcd[4*m_idx +: 4]);
      automatic bit         all_zero = 1'b1;
      automatic bit         blanked;
      automatic logic [6:0] e_seg;
      automatic logic       e_dp;
      automatic logic [N-1:0] e_sel;
      automatic string      tag;
      for (int j = m_idx; j < N; j++)
        if (bcd[4*j +: 4] != 4'd0) all_zero = 1'b0;
      blanked = ben && (m_idx != 0) && all_zero;
      if (!lit) begin
        e_sel = '1; e_seg = 7'h7F; e_dp = 1'b1; tag = "R4";
      end else begin
        e_sel = ~(N'(1) << m_idx);
        if (lamp) begin
          e_seg = '0; e_dp = 1'b0; tag = "R8";
        end else begin
          e_dp = ~dp[m_idx];
          if (blanked) begin
            e_seg = 7'h7F; tag = "R9";
          end else begin
            e_seg = numeral(v);
            if (v > 9) tag = "R6";
            else if (v == 0 && m_idx == 0) tag = "R10";
            else if (v == 0) tag = "R11";
            else tag = "R5";
          end
        end
      end
      chk({tag, " seg"}, int'(seg), int'(e_seg));
      chk(lit ? "R3 sel" : "R4 sel", int'(sel), int'(e_sel));
      chk(lit ? (lamp ? "R8 dp" : "R7 dp") : "R4 dp", int'(dpo), int'(e_dp));
      if (!$onehot0(~sel)) chk("R2 onehot", int'(sel), 0);
    end
  end

  task automatic run(input logic [4*N-1:0] b, input logic [N-1:0] d,
                     input logic lt, input logic be, input int cycles);
    @(posedge clk); #1;
    bcd = b; dp = d; lamp = lt; ben = be;
    repeat (cycles) @(posedge clk);
  endtask

  task automatic reset_check();
    @(negedge clk);
    chk("R1 sel", int'(sel), (1 << N) - 1);
    chk("R1 seg", int'(seg), 'h7F);
    chk("R1 dp", int'(dpo), 1);
  endtask

  initial begin
    reset_check();
    lamp = 1'b1;          // lamp must not reach the outputs in reset
    reset_check();
    lamp = 1'b0;
    @(posedge clk); #1 rst_n = 1'b1;
    run(16'h1234, 4'b0101, 1'b0, 1'b0, 2*N*DW);   // R5 R3 R7
    run(16'h5678, 4'b1010, 1'b0, 1'b0, 2*N*DW);   // R5
    run(16'h0909, 4'b0000, 1'b0, 1'b0, 2*N*DW);   // R5 R11
    run(16'h0000, 4'b1111, 1'b0, 1'b1, 2*N*DW);   // R9 R10 R7
    run(16'h0070, 4'b0000, 1'b0, 1'b1, 2*N*DW);   // R9 stops at nonzero
    run(16'h00A0, 4'b0000, 1'b0, 1'b1, 2*N*DW);   // R6 with R9
    run(16'hFB0C, 4'b0000, 1'b0, 1'b0, 2*N*DW);   // R6 R11
    run(16'h0000, 4'b0000, 1'b0, 1'b0, 2*N*DW);   // R11
    run(16'h0000, 4'b0000, 1'b1, 1'b1, 2*N*DW);   // R8 over R9, R4 gap
    run(16'h3010, 4'b0110, 1'b0, 1'b1, 2*N*DW);   // inner zero kept
    run(16'h0000, 4'b0000, 1'b0, 1'b1, 5);
    run(16'h0005, 4'b0000, 1'b0, 1'b1, 6);        // mid-slot change
    @(posedge clk); #1 rst_n = 1'b0;              // R1 mid-run
    reset_check();
    @(posedge clk); #1 rst_n = 1'b1;
    run(16'h9876, 4'b0001, 1'b0, 1'b0, 2*N*DW);   // R1 restart at digit 0
    @(negedge clk);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL R3 watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule